// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block turns word-wide memory requests into accesses on a narrow external bus whose lines carry first the address and then the data. A requester raises `req_valid` for one clock with an address, a direction, an I/O flag and a wait length. The controller then runs one bus access per halfword, lowest halfword first, and raises `req_ready` for one clock when the last access has finished. For a read, the assembled word is on `req_rdata` while `req_ready` is high.

Each bus access is a fixed walk through four phases. In T1 the low address half goes out with a low-half latch strobe. In T2 the high address half goes out with a high-half latch strobe. TW is the data phase and can be stretched. T3 ends the access. An I/O access leaves out T2. The output-enable strobe is built from one flop clocked on each clock edge, so it falls and rises in the middle of a clock period. This gives the external device half a cycle of settling on each side of the data phase.

Top module: `adbus_ctrl`

## Requirements
- R1: While `rst` is high, and after it until a request is accepted, `ale_lo`=0, `ale_hi`=0, `oe_n`=1, `we_n`=1, `bhe_n`=1, `bus_drive`=0, `req_ready`=0 and `bus_dout`=0.
- R2: A request is accepted on the clock edge where the controller is idle and `req_valid` is high. The following clock is T1 of halfword 0: `ale_lo`=1 for exactly that one clock. `bus_dout` carries address bits [15:0] of the halfword: bits [31:2] come from `req_addr`, bit 1 is the halfword index and bit 0 is 0. `req_addr[1:0]` is ignored.
- R3: For a memory access (`req_io`=0), the clock after T1 is T2. In T2, `ale_hi`=1 for that one clock and `bus_dout` carries address bits [31:16].
- R4: For an I/O access (`req_io`=1), T2 is left out, `ale_hi` stays 0 and TW follows T1 directly.
- R5: TW lasts `req_wait`+1 clocks, with `req_wait` captured at acceptance, so the range is 1 to 16. One access therefore takes `req_wait`+4 clocks, or `req_wait`+3 for I/O.
- R6: For a write, `we_n` is 0 during every TW clock and at no other time, and `bus_dout` carries the halfword being written: `req_wdata[15:0]` for halfword 0 and `req_wdata[31:16]` for halfword 1. For a read, `we_n` stays 1.
- R7: `oe_n` is 1 in T1 and T2. It falls half a clock after TW starts and rises half a clock after T3 starts.
- R8: Read data is taken from `bus_din` on the clock edge that ends the last TW clock. `req_rdata` = {halfword 1, halfword 0}.
- R9: The two accesses run back to back, with T1 of halfword 1 straight after T3 of halfword 0. `req_ready` is 1 for exactly the one clock after the second T3.
- R10: `bhe_n` is 0 from T1 to T3 of each access and 1 otherwise.
- R11: `bus_drive` is 1 in T1, in T2, and in TW of a write. It is 0 in read TW, in T3, in the ready clock and when idle, and `bus_dout` is 0 whenever `bus_drive` is 0.
- R12: A request that arrives while an access is in progress, including the clock in which `req_ready` is high, is ignored. The running access continues unchanged and no new T1 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O access (no high-address phase) |
| req_addr | input | 32 | Byte address; bits [1:0] ignored |
| req_wdata | input | 32 | Write word |
| req_wait | input | 4 | Data phase length minus one, in clocks |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 32 | Read word, valid with `req_ready` |
| bus_din | input | 16 | Data returned by the external device |
| bus_dout | output | 16 | Address or write data driven onto the bus |
| bus_drive | output | 1 | High while the controller owns the bus lines |
| ale_lo | output | 1 | Low address half latch strobe, active high |
| ale_hi | output | 1 | High address half latch strobe, active high |
| oe_n | output | 1 | Output enable, active low, half-cycle edges |
| we_n | output | 1 | Write enable, active low |
| bhe_n | output | 1 | High byte enable, active low |

## Verification
Every strobe, `bus_dout` and `bus_drive` is registered from the next phase, so each one shows the new phase in the clock right after the edge that enters it, and T1 appears one clock after the accepting edge. The bench builds a queue of expected phases at acceptance and compares all outputs a quarter period after each rising edge. It compares `oe_n` a second time a quarter period after the falling edge, because that output changes at mid-cycle: at the early sample it is low only when the previous clock was TW, and at the late sample it is low only in TW. The bench memory drives valid read data only while `oe_n` is low, so a capture taken one edge late returns filler and shows up as a `req_rdata` mismatch in the ready clock.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  // Ordering matters only for readability; decoding uses equality.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_DONE = 3'd5
  } phase_e;
endpackage

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int BEATS  = 2,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [WAIT_W-1:0] req_wait,
  output logic              accept,
  output phase_e            ph_q,
  output phase_e            ph_nxt,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_nxt,
  output logic              wr_nxt,
  output logic              capture
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              wr_q, io_q;
  logic [WAIT_W-1:0] wlen_q, wcnt_q, wcnt_nxt;

  always_comb begin
    ph_nxt   = ph_q;
    beat_nxt = beat_q;
    wcnt_nxt = wcnt_q;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          ph_nxt   = PH_T1;
          beat_nxt = '0;
        end
      end
      PH_T1: begin
        ph_nxt   = io_q ? PH_TW : PH_T2;
        wcnt_nxt = '0;
      end
      PH_T2: begin
        ph_nxt   = PH_TW;
        wcnt_nxt = '0;
      end
      PH_TW: begin
        if (wcnt_q == wlen_q) begin
          ph_nxt  = PH_T3;
          capture = ~wr_q;
        end else begin
          wcnt_nxt = wcnt_q + 1'b1;
        end
      end
      PH_T3: begin
        if (beat_q == LAST_BEAT) begin
          ph_nxt = PH_DONE;
        end else begin
          ph_nxt   = PH_T1;
          beat_nxt = beat_q + 1'b1;
        end
      end
      PH_DONE: ph_nxt = PH_IDLE;
      default: ph_nxt = PH_IDLE;
    endcase
  end

  assign wr_nxt = accept ? req_write : wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      beat_q <= '0;
      wcnt_q <= '0;
      wlen_q <= '0;
      wr_q   <= 1'b0;
      io_q   <= 1'b0;
    end else begin
      ph_q   <= ph_nxt;
      beat_q <= beat_nxt;
      wcnt_q <= wcnt_nxt;
      if (accept) begin
        wlen_q <= req_wait;
        wr_q   <= req_write;
        io_q   <= req_io;
      end
    end
  end
endmodule

// File: rtl/adbus_strobe.sv
module adbus_strobe
  import adbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e ph_q,
  input  phase_e ph_nxt,
  input  logic   wr_nxt,
  output logic   ale_lo,
  output logic   ale_hi,
  output logic   we_n,
  output logic   bhe_n,
  output logic   oe_n,
  output logic   bus_drive,
  output logic   req_ready
);
  logic oe_rise;  // rising-edge half: covers TW and T3
  logic oe_fall;  // falling-edge half: high from mid first TW to mid T3
  logic in_acc_n, drv_n;

  always_comb begin
    in_acc_n = (ph_nxt == PH_T1) || (ph_nxt == PH_T2) ||
               (ph_nxt == PH_TW) || (ph_nxt == PH_T3);
    drv_n    = (ph_nxt == PH_T1) || (ph_nxt == PH_T2) ||
               ((ph_nxt == PH_TW) && wr_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_lo    <= 1'b0;
      ale_hi    <= 1'b0;
      we_n      <= 1'b1;
      bhe_n     <= 1'b1;
      bus_drive <= 1'b0;
      req_ready <= 1'b0;
      oe_rise   <= 1'b0;
    end else begin
      ale_lo    <= (ph_nxt == PH_T1);
      ale_hi    <= (ph_nxt == PH_T2);
      we_n      <= ~((ph_nxt == PH_TW) && wr_nxt);
      bhe_n     <= ~in_acc_n;
      bus_drive <= drv_n;
      req_ready <= (ph_nxt == PH_DONE);
      oe_rise   <= (ph_nxt == PH_TW) || (ph_nxt == PH_T3);
    end
  end

  always_ff @(negedge clk) begin
    if (rst) oe_fall <= 1'b0;
    else     oe_fall <= (ph_q == PH_TW);
  end

  assign oe_n = ~(oe_rise & oe_fall);
endmodule

// File: rtl/adbus_dpath.sv
module adbus_dpath
  import adbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 16,
  localparam int BEATS   = DATA_W / BUS_W,
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int ALIGN   = $clog2(DATA_W / 8),
  localparam int LANE_SH = $clog2(BUS_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_e            ph_nxt,
  input  logic [BEAT_W-1:0] beat_q,
  input  logic [BEAT_W-1:0] beat_nxt,
  input  logic              wr_nxt,
  input  logic              capture,
  input  logic [BUS_W-1:0]  bus_din,
  output logic [BUS_W-1:0]  bus_dout,
  output logic [DATA_W-1:0] req_rdata
);
  logic [ADDR_W-1:ALIGN] addr_q, addr_n;
  logic [DATA_W-1:0]     wdata_q, wdata_n;
  logic [ADDR_W-1:0]     beat_a;
  logic [BUS_W-1:0]      dout_n;
  logic [BUS_W-1:0]      wlane [BEATS];
  logic                  unused_lsb;

  assign unused_lsb = ^req_addr[ALIGN-1:0];
  assign addr_n  = accept ? req_addr[ADDR_W-1:ALIGN] : addr_q;
  assign wdata_n = accept ? req_wdata : wdata_q;
  assign beat_a  = {addr_n, {ALIGN{1'b0}}} | (ADDR_W'(beat_nxt) << LANE_SH);

  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    logic [BUS_W-1:0] rlane;
    assign wlane[g] = wdata_n[g*BUS_W +: BUS_W];
    always_ff @(posedge clk) begin
      if (rst)                                        rlane <= '0;
      else if (capture && (beat_q == BEAT_W'(g)))     rlane <= bus_din;
    end
    assign req_rdata[g*BUS_W +: BUS_W] = rlane;
  end

  always_comb begin
    unique case (ph_nxt)
      PH_T1:   dout_n = beat_a[BUS_W-1:0];
      PH_T2:   dout_n = beat_a[ADDR_W-1:ADDR_W-BUS_W];
      PH_TW:   dout_n = wr_nxt ? wlane[beat_nxt] : '0;
      default: dout_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      bus_dout <= '0;
    end else begin
      addr_q   <= addr_n;
      wdata_q  <= wdata_n;
      bus_dout <= dout_n;
    end
  end
endmodule

// File: rtl/adbus_ctrl.sv
module adbus_ctrl
  import adbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0] req_wait,
  output logic              req_ready,
  output logic [DATA_W-1:0] req_rdata,
  input  logic [BUS_W-1:0]  bus_din,
  output logic [BUS_W-1:0]  bus_dout,
  output logic              bus_drive,
  output logic              ale_lo,
  output logic              ale_hi,
  output logic              oe_n,
  output logic              we_n,
  output logic              bhe_n
);
  localparam int BEATS  = DATA_W / BUS_W;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              accept, wr_nxt, capture;
  phase_e            ph_q, ph_nxt;
  logic [BEAT_W-1:0] beat_q, beat_nxt;

  adbus_seq #(.WAIT_W(WAIT_W), .BEATS(BEATS)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
    .req_wait(req_wait),
    .accept(accept), .ph_q(ph_q), .ph_nxt(ph_nxt),
    .beat_q(beat_q), .beat_nxt(beat_nxt),
    .wr_nxt(wr_nxt), .capture(capture)
  );

  adbus_strobe u_strobe (
    .clk(clk), .rst(rst),
    .ph_q(ph_q), .ph_nxt(ph_nxt), .wr_nxt(wr_nxt),
    .ale_lo(ale_lo), .ale_hi(ale_hi), .we_n(we_n), .bhe_n(bhe_n),
    .oe_n(oe_n), .bus_drive(bus_drive), .req_ready(req_ready)
  );

  adbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rst(rst),
    .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata),
    .ph_nxt(ph_nxt), .beat_q(beat_q), .beat_nxt(beat_nxt),
    .wr_nxt(wr_nxt), .capture(capture),
    .bus_din(bus_din), .bus_dout(bus_dout), .req_rdata(req_rdata)
  );
endmodule

// File: rtl/adbus_ctrl_chk.sv
module adbus_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ale_lo,
  input logic ale_hi,
  input logic oe_n,
  input logic we_n,
  input logic bhe_n,
  input logic bus_drive,
  input logic req_ready
);
  // R2
  t1_single_chk: assert property (@(posedge clk) disable iff (rst)
    ale_lo |=> !ale_lo);
  // R3
  t2_after_t1_chk: assert property (@(posedge clk) disable iff (rst)
    ale_hi |-> $past(ale_lo));
  // R7
  oe_not_in_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (!ale_lo && !ale_hi));
  // R6
  we_with_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (bus_drive && !bhe_n));
  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);
  // R10
  ready_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bhe_n && !bus_drive));
  // R11
  addr_driven_chk: assert property (@(posedge clk) disable iff (rst)
    (ale_lo || ale_hi) |-> bus_drive);
endmodule

bind adbus_ctrl adbus_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .ale_lo(ale_lo), .ale_hi(ale_hi), .oe_n(oe_n),
  .we_n(we_n), .bhe_n(bhe_n), .bus_drive(bus_drive), .req_ready(req_ready)
);

// File: tb/adbus_ctrl_tb_top.sv
module adbus_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_wait = '0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic [15:0] bus_din, bus_dout;
  logic        bus_drive, ale_lo, ale_hi, oe_n, we_n, bhe_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  adbus_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wait(req_wait), .req_ready(req_ready), .req_rdata(req_rdata),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_drive(bus_drive),
    .ale_lo(ale_lo), .ale_hi(ale_hi), .oe_n(oe_n), .we_n(we_n), .bhe_n(bhe_n)
  );

  // Bench memory: latches the address halves and answers while oe_n is low.
  logic [15:0] lat_lo = '0, lat_hi = '0;
  function automatic logic [15:0] mem_f(logic [15:0] lo, logic [15:0] hi);
    return lo ^ {hi[7:0], hi[15:8]} ^ 16'h5A3C;
  endfunction
  assign bus_din = oe_n ? 16'hBAD0 : mem_f(lat_lo, lat_hi);

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  // phases: 0 idle, 1 T1, 2 T2, 3 TW, 4 T3, 5 ready
  int ph_q[$];
  int bt_q[$];
  int cur = 0, prev = 0, cb = 0;
  logic        m_wr = 0, m_io = 0;
  logic [31:0] m_addr = 0, m_wdata = 0, m_rd = 0;

  logic        p_v = 0, p_wr = 0, p_io = 0;
  logic [31:0] p_addr = 0, p_wdata = 0;
  logic [3:0]  p_wait = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] beat_addr(logic [31:0] a, int b);
    return {a[31:2], 2'b00} | (32'(b) << 1);
  endfunction

  task automatic step();
    logic [31:0] ba;
    logic [15:0] ed;
    @(posedge clk);
    #2;
    req_valid = 1'b0;
    if (ph_q.size() > 0) begin
      cur = ph_q.pop_front();
      cb  = bt_q.pop_front();
    end else begin
      cur = 0; cb = 0;
    end
    ba = beat_addr(m_addr, cb);
    if (cur == 1)                ed = ba[15:0];
    else if (cur == 2)           ed = ba[31:16];
    else if (cur == 3 && m_wr)   ed = (cb == 1) ? m_wdata[31:16] : m_wdata[15:0];
    else                         ed = 16'h0;
    chk("R1/R2/R12 ale_lo", 32'(ale_lo), 32'(cur == 1));
    chk("R3/R4 ale_hi", 32'(ale_hi), 32'(cur == 2));
    chk("R5/R6 we_n", 32'(we_n), 32'(!(cur == 3 && m_wr)));
    chk("R10 bhe_n", 32'(bhe_n), 32'(!(cur >= 1 && cur <= 4)));
    chk("R11 bus_drive", 32'(bus_drive),
        32'(cur == 1 || cur == 2 || (cur == 3 && m_wr)));
    chk("R2/R3/R6 bus_dout", 32'(bus_dout), 32'(ed));
    chk("R5/R7 oe_n early", 32'(oe_n),
        32'(!((cur == 3 || cur == 4) && prev == 3)));
    chk("R9 req_ready", 32'(req_ready), 32'(cur == 5));
    if (cur == 5 && !m_wr) chk("R8 req_rdata", req_rdata, m_rd);
    if (ale_lo) begin lat_lo = bus_dout; lat_hi = 16'h0; end
    if (ale_hi) lat_hi = bus_dout;
    if (rst) begin ph_q.delete(); bt_q.delete(); end
    if (p_v) begin
      req_valid = 1'b1; req_write = p_wr; req_io = p_io;
      req_addr = p_addr; req_wdata = p_wdata; req_wait = p_wait;
      p_v = 0;
      // R12: only an idle controller takes the request
      if (cur == 0 && !rst) begin
        m_wr = p_wr; m_io = p_io; m_addr = p_addr; m_wdata = p_wdata;
        m_rd = 0;
        for (int b = 0; b < 2; b++) begin
          logic [31:0] a;
          a = beat_addr(p_addr, b);
          m_rd[b*16 +: 16] = mem_f(a[15:0], p_io ? 16'h0 : a[31:16]);
          ph_q.push_back(1); bt_q.push_back(b);
          if (!p_io) begin ph_q.push_back(2); bt_q.push_back(b); end
          for (int w = 0; w <= int'(p_wait); w++) begin
            ph_q.push_back(3); bt_q.push_back(b);
          end
          ph_q.push_back(4); bt_q.push_back(b);
        end
        ph_q.push_back(5); bt_q.push_back(1);
      end
    end
    #5;
    chk("R7 oe_n late", 32'(oe_n), 32'(cur != 3));
    prev = cur;
  endtask

  task automatic issue(logic wr, logic io, logic [31:0] a, logic [31:0] d,
                       logic [3:0] w);
    p_v = 1; p_wr = wr; p_io = io; p_addr = a; p_wdata = d; p_wait = w;
  endtask

  task automatic drain();
    step();
    while (ph_q.size() > 0) step();
    step(); step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1: quiet bus after reset
    chk("R1 oe_n reset", 32'(oe_n), 32'd1);
    chk("R1 bus_dout reset", 32'(bus_dout), 32'd0);
    issue(0, 0, 32'h1234_5678, 32'h0, 4'd0);            drain(); // R2 R3 R8
    issue(1, 0, 32'hCAFE_0003, 32'hA1B2_C3D4, 4'd0);    drain(); // R6, R2 lsb ignored
    issue(0, 1, 32'h0000_9ABC, 32'h0, 4'd3);            drain(); // R4 R5
    issue(1, 1, 32'h0000_4440, 32'h0F0F_F0F0, 4'd15);   drain(); // R4 R5 R6
    issue(0, 0, 32'hFFFF_FFFC, 32'h0, 4'd15);           drain(); // R5 R8
    // R12: request in mid access is ignored
    issue(0, 0, 32'h8000_1000, 32'h0, 4'd2);
    step(); step(); step();
    issue(1, 1, 32'h0000_0010, 32'h1111_2222, 4'd0);
    while (ph_q.size() > 1) step();
    // R12: request in the ready clock is ignored, then a fresh one is taken
    issue(1, 0, 32'h5555_AAAA, 32'h3333_4444, 4'd1);
    step();
    issue(0, 0, 32'h0246_8ACE, 32'h0, 4'd1);           drain(); // R9
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule